// File: doc/BRIEF.md
# Command Ring Pointer Register File

This block is the register file for a ring-buffer command queue, reached over a simple 16-bit register bus. It stores the 32-bit ring limits and pointers (base, end, producer pointer, consumer pointer, breakpoint, upper and lower fill marks). Each of these is reached as two 16-bit halves at separate offsets. It also stores a control word and a token word. It exposes a status word and four bounding-box words, both driven from outside the block, plus a set of constant performance words.

Software programs the ring through the halves. The block returns the live producer-to-consumer distance, with a correction applied when the ring has wrapped. A consumer pointer takes effect only once its upper half is written, which copies it into a shadow. Illegal accesses raise a one-cycle error pulse. Writing the upper half of the distance word raises one-cycle pulses that tell the queue logic to flush its buffer, and also its gather pipe when the new distance is zero.

Top module: `cmdq_regfile`

## Requirements
- R1: A request (`req_i` high) is answered on the next cycle with `rvalid_o` high. Without a request, `rvalid_o`, `err_o` and `rdata_o` are low on the next cycle. A write answers with `rdata_o` = 0.
- R2: After reset, all stored words read 0. This covers every pointer slot at 0x020–0x03E, the distance, control (0x002) and token (0x00E).
- R3: A write to the low half of base (0x020), end (0x024), distance (0x030), producer (0x034), consumer (0x038) or breakpoint (0x03C) stores the data with bits [4:0] cleared. The high halves (offset + 2) store all 16 bits.
- R4: Both halves of the upper fill mark (0x028/0x02A) and the lower fill mark (0x02C/0x02E) store all 16 bits unmasked.
- R5: The distance read at 0x030 (low) and 0x032 (high) is computed live from the shadow consumer S, producer P, base B and end E. It equals P − S when P ≥ S, and otherwise E − S + P − B + 32, modulo 2^32.
- R6: Writing the consumer high half (0x03A) copies the whole 32-bit consumer pointer into the shadow. Reads of 0x038/0x03A return the shadow, so a low-half write alone is not visible.
- R7: The bounding-box words at 0x010, 0x012, 0x014 and 0x016 return lanes 0 to 3 of `bbox_i` (lane k is bits 16k+15:16k). Writing them raises `err_o` and has no effect.
- R8: The fourteen metric words at 0x040–0x05A read 0. The per-vertex clock word at 0x05C reads 4. Writing any of them raises `err_o`.
- R9: A write to the performance select word (0x004) is accepted without error and discarded. A read of it raises `err_o` and returns 0.
- R10: The status word (0x000) returns `status_i`, and writing it raises `err_o`. Control (0x002) and token (0x00E) are plain read/write words.
- R11: Decoding uses the 12-bit offset. An odd or unmapped offset returns 0 with a one-cycle `err_o` pulse.
- R12: A write to 0x032 forms the new distance from the written high half and the stored low half. It then pulses `buf_rst_o` for one cycle, and also pulses `pipe_rst_o` when that distance is zero. No other access pulses either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the word |
| wdata_i | input | 16 | Write data |
| status_i | input | 16 | Status word from the queue logic |
| bbox_i | input | 64 | Four 16-bit bounding-box lanes |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Response strobe one cycle after a request |
| err_o | output | 1 | Illegal-access pulse |
| pipe_rst_o | output | 1 | Gather-pipe flush pulse |
| buf_rst_o | output | 1 | Command-buffer flush pulse |

## Verification
The assertions watch, on every cycle, the response timing, the absence of error pulses without a request, the error on bounding-box writes, the cleared low bits on base reads, the constant per-vertex word, and the rule that a pipe flush only comes together with a buffer flush, at the distance-high offset only. Only the bench's scenarios can show stored values, including the shadow latching and the visibility rules for the consumer pointer. The same goes for the two branches of the wrapped distance and for the zero test on the full distance, since these depend on write history rather than on a single cycle.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_STATUS, K_CTRL, K_PERF, K_TOKEN, K_BBOX, K_SLOT, K_METRIC, K_VTX
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] idx;
    logic       hi;
  } dec_t;

  localparam int unsigned NSLOT = 8;
  localparam logic [2:0] SLOT_BASE = 3'd0;
  localparam logic [2:0] SLOT_END  = 3'd1;
  localparam logic [2:0] SLOT_HIWM = 3'd2;
  localparam logic [2:0] SLOT_LOWM = 3'd3;
  localparam logic [2:0] SLOT_DIST = 3'd4;
  localparam logic [2:0] SLOT_WP   = 3'd5;
  localparam logic [2:0] SLOT_RP   = 3'd6;
  localparam logic [2:0] SLOT_BP   = 3'd7;

  function automatic logic slot_aligned(input logic [2:0] s);
    return !(s == SLOT_HIWM || s == SLOT_LOWM);
  endfunction
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode #(
  parameter int unsigned AW         = 12,
  parameter int unsigned NUM_METRIC = 14
) (
  input  logic [AW-1:0]   addr_i,
  output cmdq_pkg::dec_t  dec_o
);
  import cmdq_pkg::*;
  localparam logic [AW-6:0] MET_PAGE = (AW-5)'(2);

  always_comb begin
    dec_o = '{kind: K_NONE, idx: 3'd0, hi: 1'b0};
    if (!addr_i[0]) begin
      if (addr_i[AW-1:6] == '0) begin
        if (addr_i[5]) begin
          dec_o.kind = K_SLOT;
          dec_o.idx  = addr_i[4:2];
          dec_o.hi   = addr_i[1];
        end else if (addr_i[4]) begin
          if (!addr_i[3]) begin
            dec_o.kind = K_BBOX;
            dec_o.idx  = {1'b0, addr_i[2:1]};
          end
        end else if (!addr_i[3]) begin
          case (addr_i[2:1])
            2'd0:    dec_o.kind = K_STATUS;
            2'd1:    dec_o.kind = K_CTRL;
            2'd2:    dec_o.kind = K_PERF;
            default: dec_o.kind = K_NONE;
          endcase
        end else if (addr_i[2:1] == 2'd3) begin
          dec_o.kind = K_TOKEN;
        end
      end else if (addr_i[AW-1:5] == MET_PAGE) begin
        if (32'(addr_i[4:1]) < NUM_METRIC)       dec_o.kind = K_METRIC;
        else if (32'(addr_i[4:1]) == NUM_METRIC) dec_o.kind = K_VTX;
      end
    end
  end
endmodule

// File: rtl/cmdq_split_reg.sv
module cmdq_split_reg #(
  parameter int unsigned    DW      = 16,
  parameter logic [DW-1:0]  LO_MASK = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_lo_i,
  input  logic            we_hi_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      if (we_lo_i) q_o[DW-1:0]    <= wdata_i & LO_MASK;
      if (we_hi_i) q_o[2*DW-1:DW] <= wdata_i;
    end
  end
endmodule

// File: rtl/cmdq_ring_dist.sv
module cmdq_ring_dist #(
  parameter int unsigned PW    = 32,
  parameter int unsigned SLACK = 32
) (
  input  logic [PW-1:0] base_i,
  input  logic [PW-1:0] lim_i,
  input  logic [PW-1:0] wp_i,
  input  logic [PW-1:0] rp_i,
  output logic [PW-1:0] dist_o
);
  // wrapped: consumer tail to end, plus producer head from base, plus one line
  assign dist_o = (wp_i >= rp_i) ? (wp_i - rp_i)
                                 : (lim_i - rp_i + wp_i - base_i + PW'(SLACK));
endmodule

// File: rtl/cmdq_regfile.sv
module cmdq_regfile #(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 16,
  parameter int unsigned ALIGN_BITS = 5,
  parameter int unsigned NUM_METRIC = 14,
  parameter int unsigned VTX_CLKS   = 4,
  parameter int unsigned WRAP_SLACK = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   status_i,
  input  logic [4*DW-1:0] bbox_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o,
  output logic            err_o,
  output logic            pipe_rst_o,
  output logic            buf_rst_o
);
  import cmdq_pkg::*;
  localparam int unsigned   PW         = 2 * DW;
  localparam logic [DW-1:0] ALIGN_MASK = {DW{1'b1}} << ALIGN_BITS;

  dec_t dec;
  cmdq_decode #(.AW(AW), .NUM_METRIC(NUM_METRIC)) u_dec (.addr_i(addr_i), .dec_o(dec));

  logic wr, rd, slot_wr;
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign slot_wr = wr && dec.kind == K_SLOT;

  logic [PW-1:0] slot_q [NSLOT];
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cmdq_split_reg #(
      .DW(DW),
      .LO_MASK(slot_aligned(3'(s)) ? ALIGN_MASK : {DW{1'b1}})
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_lo_i(slot_wr && dec.idx == 3'(s) && !dec.hi),
      .we_hi_i(slot_wr && dec.idx == 3'(s) &&  dec.hi),
      .wdata_i(wdata_i), .q_o(slot_q[s])
    );
  end

  logic [PW-1:0] safe_rp_q, dist_live;
  logic [DW-1:0] ctrl_q, token_q;
  logic          rp_hi_wr, dist_hi_wr;
  logic [PW-1:0] dist_new;
  assign rp_hi_wr   = slot_wr && dec.idx == SLOT_RP   && dec.hi;
  assign dist_hi_wr = slot_wr && dec.idx == SLOT_DIST && dec.hi;
  assign dist_new   = {wdata_i, slot_q[SLOT_DIST][DW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      safe_rp_q <= '0;
      ctrl_q    <= '0;
      token_q   <= '0;
    end else begin
      if (rp_hi_wr) safe_rp_q <= {wdata_i, slot_q[SLOT_RP][DW-1:0]};
      if (wr && dec.kind == K_CTRL)  ctrl_q  <= wdata_i;
      if (wr && dec.kind == K_TOKEN) token_q <= wdata_i;
    end
  end

  cmdq_ring_dist #(.PW(PW), .SLACK(WRAP_SLACK)) u_dist (
    .base_i(slot_q[SLOT_BASE]), .lim_i(slot_q[SLOT_END]),
    .wp_i(slot_q[SLOT_WP]), .rp_i(safe_rp_q), .dist_o(dist_live)
  );

  logic [DW-1:0] rd_val;
  logic [PW-1:0] word;
  logic          illegal;
  always_comb begin
    rd_val  = '0;
    illegal = 1'b0;
    word    = slot_q[dec.idx];
    if (dec.idx == SLOT_RP)   word = safe_rp_q;
    if (dec.idx == SLOT_DIST) word = dist_live;
    case (dec.kind)
      K_STATUS: begin rd_val = status_i; illegal = we_i; end
      K_CTRL:   rd_val = ctrl_q;
      K_PERF:   illegal = !we_i;
      K_TOKEN:  rd_val = token_q;
      K_BBOX:   begin rd_val = bbox_i[32'(dec.idx[1:0]) * DW +: DW]; illegal = we_i; end
      K_SLOT:   rd_val = dec.hi ? word[PW-1:DW] : word[DW-1:0];
      K_METRIC: illegal = we_i;
      K_VTX:    begin rd_val = DW'(VTX_CLKS); illegal = we_i; end
      default:  illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      err_o      <= 1'b0;
      pipe_rst_o <= 1'b0;
      buf_rst_o  <= 1'b0;
    end else begin
      rvalid_o   <= req_i;
      rdata_o    <= (rd && !illegal) ? rd_val : '0;
      err_o      <= req_i && illegal;
      buf_rst_o  <= dist_hi_wr;
      pipe_rst_o <= dist_hi_wr && dist_new == '0;
    end
  end
endmodule

// File: rtl/cmdq_regfile_chk.sv
module cmdq_regfile_chk #(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 16,
  parameter int unsigned ALIGN_BITS = 5,
  parameter int unsigned VTX_CLKS   = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic          err_o,
  input logic          pipe_rst_o,
  input logic          buf_rst_o
);
  logic dist_hi_w, bbox_w;
  assign dist_hi_w = req_i && we_i && addr_i == AW'('h032);
  assign bbox_w    = req_i && we_i && addr_i[AW-1:3] == (AW-3)'(2);

  p_resp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o);
  p_no_err_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o);
  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'('h020)) |=> rdata_o[ALIGN_BITS-1:0] == '0);
  p_bbox_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bbox_w |=> err_o);
  p_vtx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'('h05C)) |=> rdata_o == DW'(VTX_CLKS));
  p_pipe_with_buf_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst_o |-> buf_rst_o);
  p_buf_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dist_hi_w |=> buf_rst_o);
  p_buf_only_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dist_hi_w |=> !buf_rst_o);
endmodule

bind cmdq_regfile cmdq_regfile_chk #(
  .AW(AW), .DW(DW), .ALIGN_BITS(ALIGN_BITS), .VTX_CLKS(VTX_CLKS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
  .pipe_rst_o(pipe_rst_o), .buf_rst_o(buf_rst_o)
);

// File: tb/sim_cmdq_regfile.sv
`timescale 1ns/1ps
module sim_cmdq_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, status = 16'h5A0F;
  logic [63:0] bbox = 64'h0400_0300_0200_0100;
  logic [15:0] rdata;
  logic        rvalid, err, pipe_rst, buf_rst;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cmdq_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .status_i(status), .bbox_i(bbox), .rdata_o(rdata),
    .rvalid_o(rvalid), .err_o(err), .pipe_rst_o(pipe_rst), .buf_rst_o(buf_rst)
  );

  // reference state
  logic [31:0] m_ring [8];
  logic [31:0] m_shadow;
  logic [15:0] m_ctl, m_tok;

  task automatic check(input logic v, input logic [15:0] d, input logic e,
                       input logic p, input logic b, input string tag);
    n_cmp++;
    if (rvalid !== v || rdata !== d || err !== e || pipe_rst !== p || buf_rst !== b) begin
      n_bad++;
      $display("FAIL %s: got v=%0b d=%h e=%0b p=%0b b=%0b, exp v=%0b d=%h e=%0b p=%0b b=%0b",
               tag, rvalid, rdata, err, pipe_rst, buf_rst, v, d, e, p, b);
    end
  endtask

  function automatic logic [31:0] live_dist();
    logic [31:0] p, s;
    p = m_ring[5]; s = m_shadow;
    if (p >= s) return p - s;
    return m_ring[1] - s + p - m_ring[0] + 32;
  endfunction

  task automatic model(input bit w, input logic [11:0] a, input logic [15:0] d,
                       output logic [15:0] rv, output bit e, output bit p, output bit b);
    int k;
    logic [31:0] word;
    rv = 0; e = 0; p = 0; b = 0;
    if (a[0]) begin e = 1; return; end
    if (a >= 12'h020 && a <= 12'h03E) begin
      k = (int'(a) - 32) / 4;
      if (w) begin
        if (!a[1]) m_ring[k][15:0] = (k == 2 || k == 3) ? d : (d & 16'hFFE0);
        else begin
          m_ring[k][31:16] = d;
          if (k == 6) m_shadow = m_ring[6];
          if (k == 4) begin b = 1; p = (m_ring[4] == 0); end
        end
      end else begin
        word = (k == 6) ? m_shadow : (k == 4) ? live_dist() : m_ring[k];
        rv = a[1] ? word[31:16] : word[15:0];
      end
    end else if (a >= 12'h010 && a <= 12'h016) begin
      if (w) e = 1; else rv = bbox[(int'(a) - 16) * 8 +: 16];
    end else if (a >= 12'h040 && a <= 12'h05A) begin
      e = w;
    end else if (a == 12'h05C) begin
      if (w) e = 1; else rv = 16'd4;
    end else if (a == 12'h000) begin
      if (w) e = 1; else rv = status;
    end else if (a == 12'h002) begin
      if (w) m_ctl = d; else rv = m_ctl;
    end else if (a == 12'h00E) begin
      if (w) m_tok = d; else rv = m_tok;
    end else if (a == 12'h004) begin
      e = !w;
    end else e = 1;
    if (w) rv = 0;
  endtask

  task automatic op(input bit w, input logic [11:0] a, input logic [15:0] d, input string tag);
    logic [15:0] rv; bit e, p, b;
    @(negedge clk);
    check(0, 0, 0, 0, 0, "R1 idle");
    req = 1; we = w; addr = a; wdata = d;
    model(w, a, d, rv, e, p, b);
    @(negedge clk);
    req = 0; we = 0;
    check(1, rv, e, p, b, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ring[i] = 0;
    m_shadow = 0; m_ctl = 0; m_tok = 0;
    repeat (3) @(negedge clk);
    check(0, 0, 0, 0, 0, "R2 reset outputs");
    rst_n = 1;
    // R2 reset contents
    for (int a = 32; a < 64; a += 2) op(0, 12'(a), 0, "R2 slot reset");
    op(0, 12'h002, 0, "R2 ctrl reset");
    op(0, 12'h00E, 0, "R2 token reset");
    // R10 plain words and status
    op(1, 12'h00E, 16'hBEEF, "R10 token wr");
    op(0, 12'h00E, 0, "R10 token rd");
    op(1, 12'h002, 16'h1234, "R10 ctrl wr");
    op(0, 12'h002, 0, "R10 ctrl rd");
    op(0, 12'h000, 0, "R10 status rd");
    op(1, 12'h000, 16'hFFFF, "R10 status wr err");
    op(0, 12'h000, 0, "R10 status unchanged");
    // R3 alignment masks
    op(1, 12'h020, 16'h123F, "R3 base lo");  op(0, 12'h020, 0, "R3 base lo rd");
    op(1, 12'h022, 16'hFFFF, "R3 base hi");  op(0, 12'h022, 0, "R3 base hi rd");
    op(1, 12'h024, 16'h00FF, "R3 end lo");   op(0, 12'h024, 0, "R3 end lo rd");
    op(1, 12'h026, 16'hFFFF, "R3 end hi");
    op(1, 12'h03C, 16'hABCD, "R3 bp lo");    op(0, 12'h03C, 0, "R3 bp lo rd");
    op(1, 12'h03E, 16'h0013, "R3 bp hi");    op(0, 12'h03E, 0, "R3 bp hi rd");
    // R4 fill marks unmasked
    op(1, 12'h028, 16'h001F, "R4 hiwm lo");  op(0, 12'h028, 0, "R4 hiwm lo rd");
    op(1, 12'h02A, 16'h8001, "R4 hiwm hi");  op(0, 12'h02A, 0, "R4 hiwm hi rd");
    op(1, 12'h02C, 16'h0007, "R4 lowm lo");  op(0, 12'h02C, 0, "R4 lowm lo rd");
    op(1, 12'h02E, 16'h7FFF, "R4 lowm hi");  op(0, 12'h02E, 0, "R4 lowm hi rd");
    // R6 shadow consumer pointer
    op(1, 12'h038, 16'h4433, "R6 rp lo");
    op(0, 12'h038, 0, "R6 rp lo hidden");
    op(1, 12'h03A, 16'hFFFF, "R6 rp hi latches");
    op(0, 12'h038, 0, "R6 rp lo visible");
    op(0, 12'h03A, 0, "R6 rp hi visible");
    // R5 distance, producer behind consumer (wrap)
    op(1, 12'h034, 16'h0041, "R3 wp lo");    op(0, 12'h034, 0, "R3 wp lo rd");
    op(1, 12'h036, 16'hFFFF, "R5 wp hi");
    op(0, 12'h030, 0, "R5 dist wrap lo");    op(0, 12'h032, 0, "R5 dist wrap hi");
    // R5 producer ahead of consumer
    op(1, 12'h034, 16'hF000, "R5 wp lo");
    op(0, 12'h030, 0, "R5 dist fwd lo");     op(0, 12'h032, 0, "R5 dist fwd hi");
    op(1, 12'h034, 16'h4420, "R5 wp equal");
    op(0, 12'h030, 0, "R5 dist zero");
    // R7 bounding box
    for (int a = 16; a <= 22; a += 2) op(0, 12'(a), 0, "R7 bbox rd");
    op(1, 12'h012, 16'h9999, "R7 bbox wr err");
    op(0, 12'h012, 0, "R7 bbox unchanged");
    // R8 metrics
    op(0, 12'h040, 0, "R8 metric first"); op(0, 12'h05A, 0, "R8 metric last");
    op(0, 12'h05C, 0, "R8 vtx clocks");   op(1, 12'h05C, 16'h7, "R8 vtx wr err");
    op(1, 12'h04A, 16'h1, "R8 metric wr err");
    // R9 perf select
    op(1, 12'h004, 16'h00FF, "R9 perf wr"); op(0, 12'h004, 0, "R9 perf rd err");
    // R11 unmapped
    op(0, 12'h003, 0, "R11 odd");  op(0, 12'h008, 0, "R11 hole");
    op(0, 12'h018, 0, "R11 hole2"); op(0, 12'h05E, 0, "R11 past vtx");
    op(1, 12'h100, 16'h1, "R11 far wr"); op(0, 12'hFFE, 0, "R11 top");
    // R12 distance writes
    op(1, 12'h030, 16'h001F, "R12 dist lo no pulse");
    op(1, 12'h032, 16'h0000, "R12 dist zero pulses");
    op(1, 12'h030, 16'h0040, "R12 dist lo");
    op(1, 12'h032, 16'h0000, "R12 dist nonzero low");
    op(1, 12'h030, 16'h0000, "R12 dist lo clr");
    op(1, 12'h032, 16'h0001, "R12 dist nonzero high");
    @(negedge clk);
    check(0, 0, 0, 0, 0, "R1 final idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule